// File: doc/BRIEF.md
# Radio Operating Mode Sequencer

This block steps a low-power packet radio through its operating modes: off, a wake-up settle, an idle standby, a held standby with the PLL stopped, a receive settle, a transmit settle, active receive and active transmit. It reads five control inputs: a power enable, a receive-role select, a chip enable, a transmit-queue-empty flag and a packet-finished strobe from the baseband. It drives the current mode, a PLL enable, and one-cycle strobes that tell the baseband to begin receiving or transmitting once the synthesizer has had its settle time.

All timing is measured in microsecond ticks from a prescaler on the system clock. The prescaler restarts whenever the mode changes, so every timed interval lasts an exact number of system clocks from its entry edge. A chip-enable pulse must stay high for a minimum time before a transmission may proceed. Continuous time in transmit is capped; hitting the cap forces the radio back to idle and sets an error flag that stays set.

Top module: `radio_mode_seq`

## Requirements
- R1: While and after reset, until `pwr_up_i` is set: `mode_o` is 0 (off), `pll_en_o`, `tx_start_o`, `rx_start_o` and `tx_err_o` are 0.
- R2: When `pwr_up_i` is low, the mode is 0 (off) on the next clock edge, from any mode.
- R3: From off with `pwr_up_i` high the mode becomes 1 (wake) for exactly WAKE_US*CLK_PER_US cycles, then 2 (idle).
- R4: From idle with `ce_i` and `prim_rx_i` high, the mode becomes 4 (receive settle) for exactly SETTLE_US*CLK_PER_US cycles, then 6 (receive), with `rx_start_o` high for the first receive cycle only. `pll_en_o` is high in modes 4 to 7 and low in modes 0 to 3.
- R5: In idle with `ce_i` high, `prim_rx_i` low and `tx_empty_i` high, the mode stays 2.
- R6: From idle with `ce_i` high, `prim_rx_i` low and `tx_empty_i` low, the mode becomes 5 (transmit settle). If `ce_i` falls before it has been high for CE_MIN_US ticks the mode returns to 2 and no `tx_start_o` occurs; otherwise after SETTLE_US*CLK_PER_US cycles the mode becomes 7 (transmit) with `tx_start_o` high for its first cycle, and `pkt_done_i` with `ce_i` low then returns the mode to 2.
- R7: In transmit, `pkt_done_i` with `ce_i` high and `tx_empty_i` low keeps mode 7 and issues another one-cycle `tx_start_o`; with `tx_empty_i` high the mode becomes 3 (held standby).
- R8: In held standby, `tx_empty_i` going low moves the mode to 5; `ce_i` going low moves it to 2.
- R9: In transmit, `pkt_done_i` with `ce_i` and `prim_rx_i` high moves the mode to 4; in receive, `prim_rx_i` low with `tx_empty_i` low moves it to 5. Active modes are entered only through their settle mode.
- R10: In receive, `ce_i` low returns the mode to 2 on the next edge.
- R11: After TX_MAX_US*CLK_PER_US consecutive cycles in mode 7 without leaving, the mode becomes 2 and `tx_err_o` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Power enable |
| prim_rx_i | input | 1 | Receive role when high, transmit role when low |
| ce_i | input | 1 | Chip enable |
| tx_empty_i | input | 1 | Transmit queue holds no payload |
| pkt_done_i | input | 1 | One-cycle strobe: baseband finished a packet |
| mode_o | output | 3 | Current mode: 0 off, 1 wake, 2 idle, 3 held, 4 rx settle, 5 tx settle, 6 rx, 7 tx |
| pll_en_o | output | 1 | PLL enable |
| tx_start_o | output | 1 | One-cycle strobe to start a packet transmission |
| rx_start_o | output | 1 | One-cycle strobe to start reception |
| tx_err_o | output | 1 | Sticky transmit-time-limit error |

## Verification
On every cycle the assertions hold the structural rules: power loss reaches off in one edge, off leaves only through wake, receive and transmit are entered only from their settle modes, start strobes coincide with the matching active mode, the error flag never clears and no transmit stretch exceeds the cap. The exact lengths of the wake and settle intervals, the chip-enable pulse qualification, the choice between repeating a packet and entering held standby, and the behaviour at the transmit cap only show in the bench scenarios, which time each mode change against the expected cycle count.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
  typedef enum logic [2:0] {
    M_OFF       = 3'd0,
    M_WAKE      = 3'd1,
    M_IDLE      = 3'd2,
    M_HOLD      = 3'd3,
    M_RX_SETTLE = 3'd4,
    M_TX_SETTLE = 3'd5,
    M_RX        = 3'd6,
    M_TX        = 3'd7
  } mode_e;
endpackage

// File: rtl/rms_tick_gen.sv
module rms_tick_gen #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (cnt_q == W'(DIV - 1));
  assign tick_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (last)      cnt_q <= '0;
    else                cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rms_interval.sv
module rms_interval #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // done on the tick that completes limit_i ticks since clear
  assign done_o = en_i && tick_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (en_i && tick_i && !done_o)   cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rms_ce_qual.sv
module rms_ce_qual #(
  parameter int unsigned MIN_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic qual_o
);
  localparam int unsigned QW = $clog2(MIN_TICKS + 1);

  logic [QW-1:0] cnt_q;
  logic          armed_q;
  logic          full;

  assign full   = (cnt_q == QW'(MIN_TICKS));
  assign qual_o = armed_q || full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!ce_i)          cnt_q <= '0;
    else if (tick_i && !full) cnt_q <= cnt_q + QW'(1);
  end

  // keeps the qualification after ce falls, until standby
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (clr_i) armed_q <= 1'b0;
    else if (full)  armed_q <= 1'b1;
  end
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import radio_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned SETTLE_US  = 130,
  parameter int unsigned CE_MIN_US  = 10,
  parameter int unsigned TX_MAX_US  = 4000,
  parameter int unsigned WAKE_US    = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       prim_rx_i,
  input  logic       ce_i,
  input  logic       tx_empty_i,
  input  logic       pkt_done_i,
  output logic [2:0] mode_o,
  output logic       pll_en_o,
  output logic       tx_start_o,
  output logic       rx_start_o,
  output logic       tx_err_o
);
  localparam int unsigned SPAN_A = (SETTLE_US > WAKE_US) ? SETTLE_US : WAKE_US;
  localparam int unsigned SPAN   = (TX_MAX_US > SPAN_A) ? TX_MAX_US : SPAN_A;
  localparam int unsigned CW     = $clog2(SPAN + 1);

  mode_e   state_q, state_d;
  logic    restart, tick;
  logic    settle_done, wd_done, ce_ok;
  logic    in_settle, in_standby, in_tx;
  logic [CW-1:0] settle_lim;
  logic    tx_start_q, rx_start_q, err_q;

  assign in_settle  = (state_q == M_WAKE) || (state_q == M_RX_SETTLE) || (state_q == M_TX_SETTLE);
  assign in_standby = (state_q == M_OFF) || (state_q == M_WAKE) || (state_q == M_IDLE) ||
                      (state_q == M_HOLD);
  assign in_tx      = (state_q == M_TX);
  assign settle_lim = (state_q == M_WAKE) ? CW'(WAKE_US) : CW'(SETTLE_US);
  assign restart    = (state_d != state_q);

  rms_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_o    (tick)
  );

  rms_interval #(.W(CW)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart),
    .en_i    (in_settle),
    .tick_i  (tick),
    .limit_i (settle_lim),
    .done_o  (settle_done)
  );

  rms_interval #(.W(CW)) u_tx_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!in_tx),
    .en_i    (in_tx),
    .tick_i  (tick),
    .limit_i (CW'(TX_MAX_US)),
    .done_o  (wd_done)
  );

  rms_ce_qual #(.MIN_TICKS(CE_MIN_US)) u_ce_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .tick_i (tick),
    .clr_i  (in_standby),
    .qual_o (ce_ok)
  );

  always_comb begin
    state_d = state_q;
    if (!pwr_up_i) begin
      state_d = M_OFF;
    end else begin
      unique case (state_q)
        M_OFF:  state_d = M_WAKE;
        M_WAKE: if (settle_done) state_d = M_IDLE;
        M_IDLE: begin
          if (ce_i && prim_rx_i)                    state_d = M_RX_SETTLE;
          else if (ce_i && !prim_rx_i && !tx_empty_i) state_d = M_TX_SETTLE;
        end
        M_HOLD: begin
          if (!ce_i)            state_d = M_IDLE;
          else if (prim_rx_i)   state_d = M_RX_SETTLE;
          else if (!tx_empty_i) state_d = M_TX_SETTLE;
        end
        M_RX_SETTLE: begin
          if (!ce_i)            state_d = M_IDLE;
          else if (settle_done) state_d = M_RX;
        end
        M_TX_SETTLE: begin
          if (!ce_i && !ce_ok)  state_d = M_IDLE;
          else if (settle_done) state_d = M_TX;
        end
        M_RX: begin
          if (!ce_i)                          state_d = M_IDLE;
          else if (!prim_rx_i && !tx_empty_i) state_d = M_TX_SETTLE;
          else if (!prim_rx_i)                state_d = M_IDLE;
        end
        M_TX: begin
          if (wd_done) begin
            state_d = M_IDLE;
          end else if (pkt_done_i) begin
            if (!ce_i)            state_d = M_IDLE;
            else if (prim_rx_i)   state_d = M_RX_SETTLE;
            else if (!tx_empty_i) state_d = M_TX;
            else                  state_d = M_HOLD;
          end
        end
        default: state_d = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= M_OFF;
      tx_start_q <= 1'b0;
      rx_start_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      tx_start_q <= (state_d == M_TX) &&
                    ((state_q == M_TX_SETTLE) || ((state_q == M_TX) && pkt_done_i));
      rx_start_q <= (state_d == M_RX) && (state_q == M_RX_SETTLE);
      if (in_tx && wd_done && pwr_up_i) err_q <= 1'b1;
    end
  end

  assign mode_o     = state_q;
  assign pll_en_o   = state_q[2];  // modes 4..7
  assign tx_start_o = tx_start_q;
  assign rx_start_o = rx_start_q;
  assign tx_err_o   = err_q;
endmodule

// File: rtl/radio_mode_seq_chk.sv
module radio_mode_seq_chk
  import radio_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned TX_MAX_US  = 4000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_up_i,
  input logic [2:0] mode_o,
  input logic       pll_en_o,
  input logic       tx_start_o,
  input logic       rx_start_o,
  input logic       tx_err_o
);
  localparam int unsigned LIM = TX_MAX_US * CLK_PER_US;

  int unsigned tx_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tx_run_q <= 0;
    else if (mode_o == M_TX)  tx_run_q <= tx_run_q + 1;
    else                      tx_run_q <= 0;
  end

  // R2
  pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> mode_o == M_OFF);

  // R3
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_OFF && mode_o != M_OFF) |-> mode_o == M_WAKE);

  // R4
  pll_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_OFF || mode_o == M_IDLE || mode_o == M_HOLD) |-> !pll_en_o);

  // R4
  rx_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_start_o |-> (mode_o == M_RX && $past(mode_o) == M_RX_SETTLE));

  // R9
  rx_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_RX && $past(mode_o) != M_RX) |-> $past(mode_o) == M_RX_SETTLE);

  // R9
  tx_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_TX && $past(mode_o) != M_TX) |-> $past(mode_o) == M_TX_SETTLE);

  // R7
  tx_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> mode_o == M_TX);

  // R11
  tx_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == M_TX |-> tx_run_q < LIM);

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |=> tx_err_o);
endmodule

bind radio_mode_seq radio_mode_seq_chk #(
  .CLK_PER_US (CLK_PER_US),
  .TX_MAX_US  (TX_MAX_US)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_up_i   (pwr_up_i),
  .mode_o     (mode_o),
  .pll_en_o   (pll_en_o),
  .tx_start_o (tx_start_o),
  .rx_start_o (rx_start_o),
  .tx_err_o   (tx_err_o)
);

// File: tb/radio_mode_seq_test.sv
`timescale 1ns/100ps
module radio_mode_seq_test;
  localparam int K   = 2;
  localparam int ST  = 5;
  localparam int CEM = 3;
  localparam int TXM = 30;
  localparam int WK  = 1;

  localparam logic [2:0] OFF = 3'd0, WAKE = 3'd1, IDLE = 3'd2, HOLD = 3'd3,
                         RXS = 3'd4, TXS = 3'd5, RX = 3'd6, TX = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_up = 0, prim_rx = 0, ce = 0, tx_empty = 1, pkt_done = 0;
  logic [2:0] mode;
  logic pll_en, tx_start, rx_start, tx_err;

  always #2.5 clk = ~clk;

  radio_mode_seq #(
    .CLK_PER_US(K), .SETTLE_US(ST), .CE_MIN_US(CEM), .TX_MAX_US(TXM), .WAKE_US(WK)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pwr_up), .prim_rx_i(prim_rx), .ce_i(ce),
    .tx_empty_i(tx_empty), .pkt_done_i(pkt_done), .mode_o(mode), .pll_en_o(pll_en),
    .tx_start_o(tx_start), .rx_start_o(rx_start), .tx_err_o(tx_err)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  typedef struct { logic [2:0] m; int dur; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] m, input int dur, input string tag);
    exp_t e;
    e.m = m; e.dur = dur; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: each mode change pops one expected item
  logic [2:0] prev_m;
  int last_stamp, tx_cnt, rx_cnt;
  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      prev_m = OFF; last_stamp = cyc; tx_cnt = 0; rx_cnt = 0;
    end else begin
      if (tx_start) tx_cnt++;
      if (rx_start) rx_cnt++;
      if (mode != prev_m) begin
        if (q.size() == 0) begin
          chk(0, "unexpected mode change", int'(mode), int'(prev_m));
        end else begin
          e = q.pop_front();
          chk(mode == e.m, e.tag, int'(mode), int'(e.m));
          if (e.dur >= 0) chk(cyc - last_stamp == e.dur, e.tag, cyc - last_stamp, e.dur);
          chk(pll_en == (mode >= RXS), "R4 pll", int'(pll_en), int'(mode >= RXS));
        end
        prev_m = mode;
        last_stamp = cyc;
      end
    end
  end

  task automatic drain(input string tag);
    int n = 0;
    while (q.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(q.size() == 0, tag, q.size(), 0);
    q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk) pkt_done = 1;
    @(negedge clk) pkt_done = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    int tb;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(mode == OFF && !pll_en && !tx_start && !rx_start && !tx_err, "R1 reset",
        int'({mode, pll_en, tx_start, rx_start, tx_err}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mode == OFF && !pll_en && !tx_err, "R1 after reset", int'(mode), 0);

    // R3 wake
    push(WAKE, -1, "R3 wake");
    push(IDLE, WK * K, "R3 wake length");
    pwr_up = 1;
    drain("R3 drain");

    // R5 no payload, transmit role
    prim_rx = 0; tx_empty = 1; ce = 1;
    repeat (6) @(negedge clk);
    chk(mode == IDLE, "R5 empty queue stays idle", int'(mode), int'(IDLE));
    ce = 0;
    repeat (2) @(negedge clk);

    // R4 receive entry
    push(RXS, -1, "R4 rx settle");
    push(RX, ST * K, "R4 rx settle length");
    prim_rx = 1; ce = 1;
    drain("R4 drain");
    chk(rx_cnt == 1, "R4 rx_start count", rx_cnt, 1);

    // R10 ce low in receive
    push(IDLE, -1, "R10 rx to idle");
    ce = 0;
    drain("R10 drain");

    // R6 short ce pulse aborts
    prim_rx = 0; tx_empty = 0;
    tb = tx_cnt;
    push(TXS, -1, "R6 short settle");
    push(IDLE, 2, "R6 short abort");
    ce = 1;
    repeat (2) @(negedge clk);
    ce = 0;
    drain("R6 short drain");
    chk(tx_cnt == tb, "R6 no tx_start on short pulse", tx_cnt, tb);

    // R6 long ce pulse: one packet
    push(TXS, -1, "R6 long settle");
    push(TX, ST * K, "R6 settle length");
    ce = 1;
    repeat (8) @(negedge clk);
    ce = 0;
    drain("R6 long drain");
    chk(tx_cnt == tb + 1, "R6 single tx_start", tx_cnt, tb + 1);
    push(IDLE, -1, "R6 one packet then idle");
    pulse_done();
    drain("R6 done drain");

    // R7 back-to-back packets then held standby
    push(TXS, -1, "R7 settle");
    push(TX, ST * K, "R7 tx");
    ce = 1;
    drain("R7 drain");
    tb = tx_cnt;
    pulse_done();
    repeat (2) @(negedge clk);
    chk(mode == TX, "R7 stays in tx", int'(mode), int'(TX));
    chk(tx_cnt == tb + 1, "R7 next tx_start", tx_cnt, tb + 1);
    tx_empty = 1;
    push(HOLD, -1, "R7 held standby");
    pulse_done();
    drain("R7 hold drain");

    // R8 payload arrives in held standby
    push(TXS, -1, "R8 settle from hold");
    push(TX, ST * K, "R8 tx");
    tx_empty = 0;
    drain("R8 drain");

    // R9 tx to rx
    push(RXS, -1, "R9 tx to rx settle");
    push(RX, ST * K, "R9 rx");
    prim_rx = 1;
    pulse_done();
    drain("R9 rx drain");

    // R9 rx to tx
    push(TXS, -1, "R9 rx to tx settle");
    push(TX, ST * K, "R9 tx");
    prim_rx = 0;
    drain("R9 tx drain");

    // R11 transmit cap
    chk(tx_err == 0, "R11 err clear before cap", int'(tx_err), 0);
    push(IDLE, TXM * K, "R11 tx cap length");
    ce = 0;
    drain("R11 drain");
    chk(tx_err == 1, "R11 err raised", int'(tx_err), 1);

    // R2 power loss from receive
    push(RXS, -1, "R2 rx settle");
    push(RX, ST * K, "R2 rx");
    prim_rx = 1; ce = 1;
    drain("R2 rx drain");
    push(OFF, -1, "R2 power off");
    @(negedge clk) pwr_up = 0;
    @(negedge clk);
    chk(mode == OFF, "R2 off next edge", int'(mode), int'(OFF));
    chk(!pll_en, "R2 pll off", int'(pll_en), 0);
    chk(tx_err == 1, "R11 err sticky", int'(tx_err), 1);
    drain("R2 drain");

    finish_run();
  end
endmodule